// File: doc/BRIEF.md
# Translation Unit Control and Status Registers

This block is the software-facing register file of a small address-translation unit. A simple strobe-based register bus selects 32-bit words by byte offset. Through it, software loads the translation table base, issues coded commands, reads back a status word and runs a masked interrupt scheme. The table walker reports page faults and bus read errors to this block as single-cycle events. This block in turn emits single-cycle pulses to neighbouring logic when a whole-cache flush, a single-page invalidate or a fault release is needed.

Paging and stall are two small mode machines. Each settles a fixed number of cycles after its command is written, so software must poll the status word, as it would on real hardware. Stall can only be entered while paging is already on. A forced-reset command returns every stored register to zero, including the table base. The register bus is plain and has no back-pressure. A write completes in the cycle it is strobed. A read returns its data with a valid flag exactly one cycle after the read strobe. Reads and writes may be strobed in the same cycle.

Top module: `xlt_ctl_regs`

Word offsets: 0x00 table base, 0x04 status, 0x08 command, 0x0C fault address, 0x10 single-page invalidate, 0x14 raw interrupts, 0x18 interrupt acknowledge, 0x1C interrupt mask, 0x20 masked interrupts, 0x24 clock gating control.

## Requirements
- R1: The table base register (offset 0x00) stores only bits 31:12 of a write, and reads return zero in bits 11:0.
- R2: Command value 0 turns paging on and value 1 turns it off. Status bit 0 shows the new state exactly PG_LAT cycles after the command write, and not before.
- R3: Command value 2 requests stall, and it is dropped unless paging is on when it is written. An accepted request sets status bit 2 after ST_LAT cycles. Status bit 31 always reads as the inverse of bit 2.
- R4: Command value 3 leaves stall: status bit 2 clears and bit 31 sets ST_LAT cycles after the write, while paging stays on.
- R5: A walker fault event sets status bit 1 and raw interrupt bit 0. It captures the faulting address at offset 0x0C and sets status bit 5 when the access was a write. A further fault while bit 1 is set does not overwrite the captured address.
- R6: Command value 5 (fault done) clears status bits 1 and 5 and drives `fault_release` high for exactly one cycle. It does not change the raw interrupt bits.
- R7: Command value 4 drives `flush_all` high for one cycle. A write to offset 0x10 drives `inval_valid` high for one cycle, with `inval_page` equal to bits 31:12 of the written word.
- R8: The masked status (offset 0x20) equals raw (0x14) AND mask (0x1C). The `irq` output is high whenever any masked bit is set.
- R9: Writing ones to offset 0x18 clears the matching raw bits. A new event on a bit in the same cycle wins over its clear.
- R10: Command value 6 (force reset) zeroes the table base, mask, raw bits, fault address, gating control, paging, stall and fault state.
- R11: Writes to unused offsets and to read-only offsets (status, fault address, masked status) change nothing. Reads of unused offsets and of write-only offsets (command, invalidate, acknowledge) return zero.
- R12: `bus_rvalid` is high exactly one cycle after each read strobe, with `bus_rdata` holding the register value as it stood at the strobe edge.
- R13: A walker bus error event sets raw interrupt bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response flag, one cycle after bus_rd |
| walk_fault | input | 1 | Page fault event from the table walker |
| walk_fault_addr | input | 32 | Virtual address of the faulting access |
| walk_fault_write | input | 1 | Faulting access was a write |
| walk_bus_err | input | 1 | Bus read error event from the table walker |
| walk_idle | input | 1 | Walker idle, shown in status bit 3 |
| replay_empty | input | 1 | Replay buffer empty, shown in status bit 4 |
| paging_on | output | 1 | Paging mode state |
| stall_on | output | 1 | Stall mode state |
| irq | output | 1 | Interrupt request |
| flush_all | output | 1 | One-cycle whole-cache flush pulse |
| fault_release | output | 1 | One-cycle pulse releasing the stalled faulting request |
| inval_valid | output | 1 | One-cycle single-page invalidate pulse |
| inval_page | output | 32-PAGE_LSB | Page number to invalidate |

## Verification
A mode machine that settles one cycle early or late shows up as a status word that reads wrongly in the single cycle bracketing the PG_LAT or ST_LAT deadline. For that reason, the bench polls the status word at both the last old-value edge and the first new-value edge. A raw or mask bit stuck or lost in the interrupt logic appears on `irq` in the cycle after the event or acknowledge, and on the next read of 0x14 or 0x20. A fault capture that is overwritten or never cleared shows on the next read of 0x0C or of the status word. A force reset that misses a register shows as a non-zero read of that register immediately afterward.

// File: rtl/xlt_ctl_pkg.sv
package xlt_ctl_pkg;
  localparam int unsigned WIDX_BASE   = 0;
  localparam int unsigned WIDX_STATUS = 1;
  localparam int unsigned WIDX_CMD    = 2;
  localparam int unsigned WIDX_FADDR  = 3;
  localparam int unsigned WIDX_INVAL  = 4;
  localparam int unsigned WIDX_RAW    = 5;
  localparam int unsigned WIDX_ACK    = 6;
  localparam int unsigned WIDX_MASK   = 7;
  localparam int unsigned WIDX_MSTAT  = 8;
  localparam int unsigned WIDX_GATE   = 9;

  localparam logic [31:0] CMD_PG_ON  = 32'd0;
  localparam logic [31:0] CMD_PG_OFF = 32'd1;
  localparam logic [31:0] CMD_ST_ON  = 32'd2;
  localparam logic [31:0] CMD_ST_OFF = 32'd3;
  localparam logic [31:0] CMD_FLUSH  = 32'd4;
  localparam logic [31:0] CMD_DONE   = 32'd5;
  localparam logic [31:0] CMD_FORCE  = 32'd6;

  localparam int unsigned ST_PAGING  = 0;
  localparam int unsigned ST_FAULT   = 1;
  localparam int unsigned ST_STALL   = 2;
  localparam int unsigned ST_IDLE    = 3;
  localparam int unsigned ST_REPLAY  = 4;
  localparam int unsigned ST_FWRITE  = 5;
  localparam int unsigned ST_NSTALL  = 31;

  localparam int unsigned IRQ_FAULT  = 0;
  localparam int unsigned IRQ_BUSERR = 1;
  localparam int unsigned IRQ_N      = 2;

  typedef struct packed {
    logic base;
    logic cmd;
    logic inval;
    logic ack;
    logic mask;
    logic gate;
  } wr_sel_t;

  typedef struct packed {
    logic pg_on;
    logic pg_off;
    logic st_on;
    logic st_off;
    logic flush;
    logic done;
    logic force_clr;
  } cmd_dec_t;
endpackage

// File: rtl/xlt_mode_fsm.sv
module xlt_mode_fsm #(
  parameter int unsigned LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic req_valid,
  input  logic req_on,
  output logic state_on,
  output logic busy
);
  localparam int unsigned CNT_W = (LAT < 2) ? 1 : $clog2(LAT);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LAT - 1);

  logic             on_q;
  logic             pend_q;
  logic             tgt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      pend_q <= 1'b0;
      tgt_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (clear) begin
      on_q   <= 1'b0;
      pend_q <= 1'b0;
      tgt_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (req_valid) begin
      pend_q <= 1'b1;
      tgt_q  <= req_on;
      cnt_q  <= CNT_LOAD;
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        on_q   <= tgt_q;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign state_on = on_q;
  assign busy     = pend_q;

  // R2 / R4: a pending request lands on its target when the countdown ends
  p_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cnt_q == '0 && !clear && !req_valid) |=> (on_q == $past(tgt_q)));

  // R2: no state change without a finished countdown
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !clear) |=> $stable(on_q));

  // R10: clear drops everything
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!on_q && !pend_q));
endmodule

// File: rtl/xlt_irq_unit.sv
module xlt_irq_unit #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_all,
  input  logic [N-1:0] set_evt,
  input  logic         ack_we,
  input  logic [N-1:0] ack_bits,
  input  logic         mask_we,
  input  logic [N-1:0] mask_bits,
  output logic [N-1:0] raw,
  output logic [N-1:0] mask,
  output logic [N-1:0] masked,
  output logic         irq
);
  logic [N-1:0] raw_q;
  logic [N-1:0] mask_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      raw_q[i] <= 1'b0;
      else if (clear_all)              raw_q[i] <= 1'b0;
      else if (set_evt[i])             raw_q[i] <= 1'b1;
      else if (ack_we && ack_bits[i])  raw_q[i] <= 1'b0;
    end

    // R9: acknowledge clears a bit unless an event arrives with it
    p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && ack_bits[i] && !set_evt[i] && !clear_all) |=> !raw_q[i]);

    // R5 / R13: an event always records its bit
    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_evt[i] && !clear_all) |=> raw_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '0;
    else if (clear_all) mask_q <= '0;
    else if (mask_we)  mask_q <= mask_bits;
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign masked = raw_q & mask_q;
  assign irq    = |masked;

  // R8: interrupt follows the registered state one cycle after an unmasked event
  p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_evt & mask_q) && !clear_all && !mask_we) |=> irq);
endmodule

// File: rtl/xlt_fault_cap.sv
module xlt_fault_cap #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          evt,
  input  logic [AW-1:0] evt_addr,
  input  logic          evt_write,
  input  logic          done,
  output logic          active,
  output logic          is_write,
  output logic [AW-1:0] addr
);
  logic          act_q;
  logic          wr_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else if (clear) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else if (done) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (evt && !act_q) begin
      act_q  <= 1'b1;
      wr_q   <= evt_write;
      addr_q <= evt_addr;
    end
  end

  assign active   = act_q;
  assign is_write = wr_q;
  assign addr     = addr_q;

  // R5: a captured fault keeps its address until released
  p_fault_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !done && !clear) |=> ($stable(addr_q) && act_q));

  // R6: fault done releases the capture
  p_fault_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!act_q && !wr_q));
endmodule

// File: rtl/xlt_ctl_regs.sv
module xlt_ctl_regs
  import xlt_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned PAGE_LSB = 12,
  parameter int unsigned PG_LAT   = 3,
  parameter int unsigned ST_LAT   = 2,
  parameter int unsigned GATE_W   = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  bus_rvalid,
  input  logic                  walk_fault,
  input  logic [31:0]           walk_fault_addr,
  input  logic                  walk_fault_write,
  input  logic                  walk_bus_err,
  input  logic                  walk_idle,
  input  logic                  replay_empty,
  output logic                  paging_on,
  output logic                  stall_on,
  output logic                  irq,
  output logic                  flush_all,
  output logic                  fault_release,
  output logic                  inval_valid,
  output logic [31-PAGE_LSB:0]  inval_page
);
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam int unsigned PN_W   = 32 - PAGE_LSB;

  logic [WIDX_W-1:0] widx;
  wr_sel_t           wsel;
  cmd_dec_t          cmd;

  assign widx = bus_addr[ADDR_W-1:2];

  // write decode
  always_comb begin
    wsel       = '0;
    wsel.base  = bus_wr && (widx == WIDX_W'(WIDX_BASE));
    wsel.cmd   = bus_wr && (widx == WIDX_W'(WIDX_CMD));
    wsel.inval = bus_wr && (widx == WIDX_W'(WIDX_INVAL));
    wsel.ack   = bus_wr && (widx == WIDX_W'(WIDX_ACK));
    wsel.mask  = bus_wr && (widx == WIDX_W'(WIDX_MASK));
    wsel.gate  = bus_wr && (widx == WIDX_W'(WIDX_GATE));
  end

  // command decode; values other than the seven codes do nothing
  always_comb begin
    cmd = '0;
    if (wsel.cmd) begin
      case (bus_wdata)
        CMD_PG_ON:  cmd.pg_on     = 1'b1;
        CMD_PG_OFF: cmd.pg_off    = 1'b1;
        CMD_ST_ON:  cmd.st_on     = 1'b1;
        CMD_ST_OFF: cmd.st_off    = 1'b1;
        CMD_FLUSH:  cmd.flush     = 1'b1;
        CMD_DONE:   cmd.done      = 1'b1;
        CMD_FORCE:  cmd.force_clr = 1'b1;
        default:    cmd = '0;
      endcase
    end
  end

  // mode machines
  logic pg_busy, st_busy;
  logic st_req;

  assign st_req = (cmd.st_on && paging_on) || cmd.st_off;

  xlt_mode_fsm #(.LAT(PG_LAT)) u_paging (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cmd.force_clr),
    .req_valid (cmd.pg_on || cmd.pg_off),
    .req_on    (cmd.pg_on),
    .state_on  (paging_on),
    .busy      (pg_busy)
  );

  xlt_mode_fsm #(.LAT(ST_LAT)) u_stall (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cmd.force_clr),
    .req_valid (st_req),
    .req_on    (cmd.st_on),
    .state_on  (stall_on),
    .busy      (st_busy)
  );

  // interrupts
  logic [IRQ_N-1:0] irq_set, irq_raw, irq_mask, irq_masked;

  always_comb begin
    irq_set             = '0;
    irq_set[IRQ_FAULT]  = walk_fault;
    irq_set[IRQ_BUSERR] = walk_bus_err;
  end

  xlt_irq_unit #(.N(IRQ_N)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (cmd.force_clr),
    .set_evt   (irq_set),
    .ack_we    (wsel.ack),
    .ack_bits  (bus_wdata[IRQ_N-1:0]),
    .mask_we   (wsel.mask),
    .mask_bits (bus_wdata[IRQ_N-1:0]),
    .raw       (irq_raw),
    .mask      (irq_mask),
    .masked    (irq_masked),
    .irq       (irq)
  );

  // fault capture
  logic        flt_active, flt_write;
  logic [31:0] flt_addr;

  xlt_fault_cap #(.AW(32)) u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cmd.force_clr),
    .evt       (walk_fault),
    .evt_addr  (walk_fault_addr),
    .evt_write (walk_fault_write),
    .done      (cmd.done),
    .active    (flt_active),
    .is_write  (flt_write),
    .addr      (flt_addr)
  );

  // plain storage registers
  logic [PN_W-1:0]   base_q;
  logic [GATE_W-1:0] gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      gate_q <= '0;
    end else if (cmd.force_clr) begin
      base_q <= '0;
      gate_q <= '0;
    end else begin
      if (wsel.base) base_q <= bus_wdata[31:PAGE_LSB];
      if (wsel.gate) gate_q <= bus_wdata[GATE_W-1:0];
    end
  end

  // outgoing pulses
  logic            flush_q, rel_q, inv_q;
  logic [PN_W-1:0] inv_pg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q  <= 1'b0;
      rel_q    <= 1'b0;
      inv_q    <= 1'b0;
      inv_pg_q <= '0;
    end else begin
      flush_q <= cmd.flush;
      rel_q   <= cmd.done;
      inv_q   <= wsel.inval;
      if (wsel.inval) inv_pg_q <= bus_wdata[31:PAGE_LSB];
    end
  end

  assign flush_all     = flush_q;
  assign fault_release = rel_q;
  assign inval_valid   = inv_q;
  assign inval_page    = inv_pg_q;

  // status word
  logic [31:0] status_w;

  always_comb begin
    status_w             = '0;
    status_w[ST_PAGING]  = paging_on;
    status_w[ST_FAULT]   = flt_active;
    status_w[ST_STALL]   = stall_on;
    status_w[ST_IDLE]    = walk_idle;
    status_w[ST_REPLAY]  = replay_empty;
    status_w[ST_FWRITE]  = flt_write;
    status_w[ST_NSTALL]  = !stall_on;
  end

  // read path
  logic [31:0] rd_mux;
  logic [31:0] rdata_q;
  logic        rvalid_q;

  always_comb begin
    rd_mux = '0;
    case (widx)
      WIDX_W'(WIDX_BASE):   rd_mux = {base_q, {PAGE_LSB{1'b0}}};
      WIDX_W'(WIDX_STATUS): rd_mux = status_w;
      WIDX_W'(WIDX_FADDR):  rd_mux = flt_addr;
      WIDX_W'(WIDX_RAW):    rd_mux = 32'(irq_raw);
      WIDX_W'(WIDX_MASK):   rd_mux = 32'(irq_mask);
      WIDX_W'(WIDX_MSTAT):  rd_mux = 32'(irq_masked);
      WIDX_W'(WIDX_GATE):   rd_mux = 32'(gate_q);
      default:              rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R3: a stall request written while paging is off starts nothing
  p_stall_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.st_on && !paging_on && !st_busy) |=> !st_busy);

  // R10: force reset empties the base and both modes
  p_force_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.force_clr |=> (base_q == '0 && !paging_on && !stall_on && !pg_busy));

  // R12: every read strobe is answered on the next cycle
  p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R7: flush is a single-cycle pulse
  p_flush_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !cmd.flush) |=> !flush_all);
endmodule

// File: tb/tb_xlt_ctl_regs.sv
module tb_xlt_ctl_regs;
  localparam int unsigned PG_LAT = 3;
  localparam int unsigned ST_LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        walk_fault = 1'b0, walk_fault_write = 1'b0, walk_bus_err = 1'b0;
  logic [31:0] walk_fault_addr = '0;
  logic        walk_idle = 1'b1, replay_empty = 1'b1;
  logic        paging_on, stall_on, irq, flush_all, fault_release, inval_valid;
  logic [19:0] inval_page;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  xlt_ctl_regs #(.PG_LAT(PG_LAT), .ST_LAT(ST_LAT)) dut (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata, .bus_rvalid,
    .walk_fault, .walk_fault_addr, .walk_fault_write, .walk_bus_err,
    .walk_idle, .replay_empty, .paging_on, .stall_on, .irq,
    .flush_all, .fault_release, .inval_valid, .inval_page
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: queue the expected read value, monitor compares on response
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic fault(input logic [31:0] a, input logic w);
    walk_fault = 1'b1; walk_fault_addr = a; walk_fault_write = w;
    @(negedge clk);
    walk_fault = 1'b0;
  endtask

  task automatic buserr();
    walk_bus_err = 1'b1;
    @(negedge clk);
    walk_bus_err = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12: response with no read pending, got %h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // reset state
    rd(8'h04, 32'h8000_0018, "R3 reset status");
    rd(8'h00, 32'h0, "R1 reset base");
    rd(8'h14, 32'h0, "R8 reset raw");
    check("R8 reset irq", {31'b0, irq}, 32'h0);

    // R1 base register
    wr(8'h00, 32'hCAFE_BABE);
    rd(8'h00, 32'hCAFE_B000, "R1 base low bits");

    // R11 unused and read-only offsets
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, 32'h0, "R11 unused read");
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h04, 32'h8000_0018, "R11 status write ignored");
    rd(8'h00, 32'hCAFE_B000, "R11 base untouched");
    rd(8'h08, 32'h0, "R11 command reads zero");

    // R3 stall refused while paging off
    wr(8'h08, 32'd2);
    idle(5);
    rd(8'h04, 32'h8000_0018, "R3 stall refused");

    // R2 paging on, poll both sides of the deadline
    wr(8'h08, 32'd0);
    idle(PG_LAT - 1);
    rd(8'h04, 32'h8000_0018, "R2 paging not yet");
    rd(8'h04, 32'h8000_0019, "R2 paging on");

    // R3 stall accepted
    wr(8'h08, 32'd2);
    idle(ST_LAT - 1);
    rd(8'h04, 32'h8000_0019, "R3 stall not yet");
    rd(8'h04, 32'h0000_001D, "R3 stall on");

    // R4 leave stall
    wr(8'h08, 32'd3);
    idle(ST_LAT - 1);
    rd(8'h04, 32'h0000_001D, "R4 stall still on");
    rd(8'h04, 32'h8000_0019, "R4 stall off");

    // R5 fault capture
    fault(32'h0040_1234, 1'b1);
    check("R8 masked irq low", {31'b0, irq}, 32'h0);
    rd(8'h04, 32'h8000_003B, "R5 fault status");
    rd(8'h0C, 32'h0040_1234, "R5 fault address");
    rd(8'h14, 32'h1, "R5 raw fault bit");
    fault(32'h0000_5555, 1'b0);
    rd(8'h0C, 32'h0040_1234, "R5 address held");

    // R8 masking
    rd(8'h20, 32'h0, "R8 masked zero");
    wr(8'h1C, 32'h3);
    check("R8 irq high", {31'b0, irq}, 32'h1);
    rd(8'h20, 32'h1, "R8 masked one");

    // R6 fault done
    wr(8'h08, 32'd5);
    check("R6 release pulse", {31'b0, fault_release}, 32'h1);
    idle(1);
    check("R6 release single", {31'b0, fault_release}, 32'h0);
    rd(8'h04, 32'h8000_0019, "R6 fault cleared");
    check("R6 raw kept, irq high", {31'b0, irq}, 32'h1);

    // R9 acknowledge
    wr(8'h18, 32'h1);
    check("R9 irq after ack", {31'b0, irq}, 32'h0);
    rd(8'h14, 32'h0, "R9 raw cleared");
    rd(8'h18, 32'h0, "R11 ack reads zero");
    walk_fault = 1'b1; walk_fault_addr = 32'h0000_7000;
    wr(8'h18, 32'h1);
    walk_fault = 1'b0;
    rd(8'h14, 32'h1, "R9 event wins over ack");
    rd(8'h0C, 32'h0000_7000, "R5 new capture after done");
    wr(8'h08, 32'd5);
    wr(8'h18, 32'h1);

    // R13 bus error
    buserr();
    check("R13 irq on bus error", {31'b0, irq}, 32'h1);
    rd(8'h14, 32'h2, "R13 raw bus error");
    rd(8'h20, 32'h2, "R8 masked bus error");

    // R7 pulses
    wr(8'h08, 32'd4);
    check("R7 flush pulse", {31'b0, flush_all}, 32'h1);
    idle(1);
    check("R7 flush single", {31'b0, flush_all}, 32'h0);
    wr(8'h10, 32'h00AB_C123);
    check("R7 inval pulse", {31'b0, inval_valid}, 32'h1);
    check("R7 inval page", {12'b0, inval_page}, 32'h0000_0ABC);
    idle(1);
    check("R7 inval single", {31'b0, inval_valid}, 32'h0);
    rd(8'h10, 32'h0, "R11 inval reads zero");

    // gating register
    wr(8'h24, 32'h1);
    rd(8'h24, 32'h1, "R11 gating stored");

    // R10 force reset
    fault(32'h0012_3000, 1'b0);
    wr(8'h08, 32'd6);
    rd(8'h00, 32'h0, "R10 base cleared");
    rd(8'h1C, 32'h0, "R10 mask cleared");
    rd(8'h14, 32'h0, "R10 raw cleared");
    rd(8'h0C, 32'h0, "R10 fault address cleared");
    rd(8'h24, 32'h0, "R10 gating cleared");
    rd(8'h04, 32'h8000_0018, "R10 status cleared");
    check("R10 paging output", {31'b0, paging_on}, 32'h0);
    check("R10 irq low", {31'b0, irq}, 32'h0);

    idle(3);
    check("R12 all reads answered", 32'(exp_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule